// File: doc/BRIEF.md
# Per-Sector Write Protection Gate

This block decides, for a flash-style array divided into sectors, whether a program or an erase aimed at one sector may go ahead. Each sector carries two protection flags. The first is a persistent flag, held here as a mirror of non-volatile storage that lives outside the block. The second is a dynamic flag that is volatile and comes up protecting every sector. A request is granted only when both flags for the addressed sector are clear. The grant or denial is answered in the same cycle as the request.

Changes to the persistent flags are governed by a volatile freeze bit. While the freeze bit is set, attempts to program or bulk-erase the persistent flags are refused, and a rejection pulse is raised. A configuration input, driven from a one-time-programmable word, picks between two schemes:

- **Guarded scheme.** The freeze bit starts set and can be released only by presenting a 64-bit key that equals the stored key.
- **Simple scheme.** The freeze bit starts clear, and once set it stays set until reset.

The command sequencer and the non-volatile storage sit outside the block. They drive the strobes and the mirror-load path.

Top module: `sprot_gate`

## Requirements
- R1: While rst_n is low at a clock edge, the next state has every dyn_bits bit at 1, every pers_bits bit at 0, locked equal to pw_mode, and pw_err and pers_rej at 0.
- R2: In the same cycle as the request, prog_ok (erase_ok) is 1 exactly when prog_req (erase_req) is 1 and both dyn_bits[sec_idx] and pers_bits[sec_idx] are 0. prog_deny (erase_deny) is 1 exactly when the request is 1 and the matching ok output is 0. With no request, both outputs of that pair are 0.
- R3: dyn_set writes 1 and dyn_clr writes 0 to dyn_bits[sec_idx], visible in the next cycle, whatever the value of locked. When both are high, dyn_set wins.
- R4: nv_load copies nv_bits into pers_bits in the next cycle, whatever the value of locked. It takes priority over pers_prog and pers_erase_all, which are then ignored, and pers_rej stays 0.
- R5: With locked at 0, pers_prog sets pers_bits[sec_idx] and pers_erase_all clears every pers_bits bit, each in the next cycle. When both are high, the erase wins.
- R6: With locked at 1 and no nv_load, pers_prog or pers_erase_all leaves pers_bits unchanged and pulses pers_rej high for exactly the next cycle.
- R7: lock_set drives locked to 1 in the next cycle under either scheme. In the same cycle it overrides unlock_req, which then performs no compare and raises no pw_err.
- R8: With pw_mode at 1, unlock_req with pw_cand equal to pw_stored clears locked in the next cycle. A mismatch leaves locked unchanged and pulses pw_err for that one next cycle.
- R9: With pw_mode at 0, unlock_req has no effect: locked keeps its value and pw_err stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pw_mode | input | 1 | Scheme select from the configuration word: 1 guarded, 0 simple |
| pw_stored | input | 64 | Stored release key |
| sec_idx | input | SEC_W | Addressed sector |
| prog_req | input | 1 | Program request to sector sec_idx |
| erase_req | input | 1 | Erase request to sector sec_idx |
| dyn_set | input | 1 | Set dynamic flag of sec_idx |
| dyn_clr | input | 1 | Clear dynamic flag of sec_idx |
| nv_load | input | 1 | Load persistent mirror from storage |
| nv_bits | input | NUM_SECT | Persistent flag values from storage |
| pers_prog | input | 1 | Set persistent flag of sec_idx |
| pers_erase_all | input | 1 | Clear all persistent flags |
| lock_set | input | 1 | Set the freeze bit |
| unlock_req | input | 1 | Try to release the freeze bit |
| pw_cand | input | 64 | Candidate key for unlock_req |
| prog_ok | output | 1 | Program granted |
| prog_deny | output | 1 | Program refused |
| erase_ok | output | 1 | Erase granted |
| erase_deny | output | 1 | Erase refused |
| dyn_bits | output | NUM_SECT | Dynamic flags |
| pers_bits | output | NUM_SECT | Persistent flag mirror |
| locked | output | 1 | Freeze bit |
| pw_err | output | 1 | Key mismatch pulse |
| pers_rej | output | 1 | Persistent change refused pulse |

## Verification
The bench attacks the freeze bit's interplay with the persistent flags: an edit attempted while frozen, a mirror load while frozen, and erase and program issued together. A design that checked the freeze bit one cycle late would let an edit through just after lock_set. A design that gave program priority over erase would leave one flag set. Key handling is exercised with near-miss candidates, with a correct key under the simple scheme, and with lock_set arriving together with a matching key. Each of these separates a design that compares unconditionally, or that lets the release win, from a correct one. The dynamic flags are flipped while the freeze bit is set, and set and clear are driven on the same sector together, which exposes wrongly shared gating and the wrong priority.

// File: rtl/sprot_pkg.sv
package sprot_pkg;
    localparam int KEY_W = 64;

    typedef enum logic [1:0] {
        LK_HOLD,
        LK_SET,
        LK_TRY
    } lock_cmd_e;

    typedef struct packed {
        logic locked;
        logic pw_err;
    } lock_state_t;
endpackage

// File: rtl/sprot_dyn_bank.sv
module sprot_dyn_bank #(
    parameter int NUM_SECT = 16,
    localparam int SEC_W = $clog2(NUM_SECT)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SEC_W-1:0]    sec_idx,
    input  logic                dyn_set,
    input  logic                dyn_clr,
    output logic [NUM_SECT-1:0] bits_q
);
    logic [NUM_SECT-1:0] bits_d;

    // one next-value slice per sector
    for (genvar s = 0; s < NUM_SECT; s++) begin : g_sect
        logic hit;
        assign hit = (sec_idx == SEC_W'(s));
        always_comb begin
            bits_d[s] = bits_q[s];
            if (hit && dyn_set) begin
                bits_d[s] = 1'b1;
            end else if (hit && dyn_clr) begin
                bits_d[s] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bits_q <= '1;
        end else begin
            bits_q <= bits_d;
        end
    end
endmodule

// File: rtl/sprot_pers_bank.sv
module sprot_pers_bank #(
    parameter int NUM_SECT = 16,
    localparam int SEC_W = $clog2(NUM_SECT)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frozen,
    input  logic                nv_load,
    input  logic [NUM_SECT-1:0] nv_bits,
    input  logic [SEC_W-1:0]    sec_idx,
    input  logic                pers_prog,
    input  logic                pers_erase_all,
    output logic [NUM_SECT-1:0] bits_q,
    output logic                rej_q
);
    typedef struct packed {
        logic [NUM_SECT-1:0] bits;
        logic                rej;
    } pers_state_t;

    pers_state_t st_d, st_q;
    logic        edit;

    assign edit = pers_prog | pers_erase_all;

    always_comb begin
        st_d     = st_q;
        st_d.rej = 1'b0;
        if (nv_load) begin
            st_d.bits = nv_bits;
        end else if (edit && frozen) begin
            st_d.rej = 1'b1;
        end else if (pers_erase_all) begin
            st_d.bits = '0;
        end else if (pers_prog) begin
            st_d.bits[sec_idx] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bits_q = st_q.bits;
    assign rej_q  = st_q.rej;
endmodule

// File: rtl/sprot_lock_ctrl.sv
module sprot_lock_ctrl
    import sprot_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pw_mode,
    input  logic             lock_set,
    input  logic             unlock_req,
    input  logic [KEY_W-1:0] pw_cand,
    input  logic [KEY_W-1:0] pw_stored,
    output logic             locked_q,
    output logic             pw_err_q
);
    lock_state_t st_d, st_q;
    lock_cmd_e   cmd;
    logic        key_match;

    assign key_match = (pw_cand == pw_stored);

    always_comb begin
        if (lock_set) begin
            cmd = LK_SET;
        end else if (unlock_req && pw_mode) begin
            cmd = LK_TRY;
        end else begin
            cmd = LK_HOLD;
        end
    end

    always_comb begin
        st_d        = st_q;
        st_d.pw_err = 1'b0;
        unique case (cmd)
            LK_SET: st_d.locked = 1'b1;
            LK_TRY: begin
                if (key_match) begin
                    st_d.locked = 1'b0;
                end else begin
                    st_d.pw_err = 1'b1;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.locked <= pw_mode;
            st_q.pw_err <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign locked_q = st_q.locked;
    assign pw_err_q = st_q.pw_err;
endmodule

// File: rtl/sprot_gate.sv
module sprot_gate
    import sprot_pkg::*;
#(
    parameter int NUM_SECT = 16,
    localparam int SEC_W = $clog2(NUM_SECT)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pw_mode,
    input  logic [KEY_W-1:0]    pw_stored,
    input  logic [SEC_W-1:0]    sec_idx,
    input  logic                prog_req,
    input  logic                erase_req,
    input  logic                dyn_set,
    input  logic                dyn_clr,
    input  logic                nv_load,
    input  logic [NUM_SECT-1:0] nv_bits,
    input  logic                pers_prog,
    input  logic                pers_erase_all,
    input  logic                lock_set,
    input  logic                unlock_req,
    input  logic [KEY_W-1:0]    pw_cand,
    output logic                prog_ok,
    output logic                prog_deny,
    output logic                erase_ok,
    output logic                erase_deny,
    output logic [NUM_SECT-1:0] dyn_bits,
    output logic [NUM_SECT-1:0] pers_bits,
    output logic                locked,
    output logic                pw_err,
    output logic                pers_rej
);
    logic guarded;

    sprot_lock_ctrl u_lock (
        .clk        (clk),
        .rst_n      (rst_n),
        .pw_mode    (pw_mode),
        .lock_set   (lock_set),
        .unlock_req (unlock_req),
        .pw_cand    (pw_cand),
        .pw_stored  (pw_stored),
        .locked_q   (locked),
        .pw_err_q   (pw_err)
    );

    sprot_dyn_bank #(.NUM_SECT(NUM_SECT)) u_dyn (
        .clk     (clk),
        .rst_n   (rst_n),
        .sec_idx (sec_idx),
        .dyn_set (dyn_set),
        .dyn_clr (dyn_clr),
        .bits_q  (dyn_bits)
    );

    sprot_pers_bank #(.NUM_SECT(NUM_SECT)) u_pers (
        .clk            (clk),
        .rst_n          (rst_n),
        .frozen         (locked),
        .nv_load        (nv_load),
        .nv_bits        (nv_bits),
        .sec_idx        (sec_idx),
        .pers_prog      (pers_prog),
        .pers_erase_all (pers_erase_all),
        .bits_q         (pers_bits),
        .rej_q          (pers_rej)
    );

    // either layer blocks the addressed sector
    always_comb begin
        guarded    = dyn_bits[sec_idx] | pers_bits[sec_idx];
        prog_ok    = prog_req & ~guarded;
        prog_deny  = prog_req & guarded;
        erase_ok   = erase_req & ~guarded;
        erase_deny = erase_req & guarded;
    end
endmodule

// File: rtl/sprot_gate_chk.sv
module sprot_gate_chk
    import sprot_pkg::*;
#(
    parameter int NUM_SECT = 16,
    localparam int SEC_W = $clog2(NUM_SECT)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                pw_mode,
    input logic [KEY_W-1:0]    pw_stored,
    input logic [SEC_W-1:0]    sec_idx,
    input logic                prog_req,
    input logic                erase_req,
    input logic                dyn_set,
    input logic                dyn_clr,
    input logic                nv_load,
    input logic [NUM_SECT-1:0] nv_bits,
    input logic                pers_prog,
    input logic                pers_erase_all,
    input logic                lock_set,
    input logic                unlock_req,
    input logic [KEY_W-1:0]    pw_cand,
    input logic                prog_ok,
    input logic                prog_deny,
    input logic                erase_ok,
    input logic                erase_deny,
    input logic [NUM_SECT-1:0] dyn_bits,
    input logic [NUM_SECT-1:0] pers_bits,
    input logic                locked,
    input logic                pw_err,
    input logic                pers_rej
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (dyn_bits == '1) && (pers_bits == '0) && !pw_err && !pers_rej);

    // R2
    prog_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_ok |-> prog_req && !prog_deny && !dyn_bits[sec_idx] && !pers_bits[sec_idx]);

    // R2
    erase_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !erase_req |-> !erase_ok && !erase_deny);

    // R3
    dyn_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dyn_set |=> dyn_bits[$past(sec_idx)]);

    // R4
    nv_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nv_load |=> pers_bits == $past(nv_bits) && !pers_rej);

    // R6
    frozen_edit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && (pers_prog || pers_erase_all) && !nv_load) |=> pers_rej && $stable(pers_bits));

    // R7
    lock_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock_set |=> locked && !pw_err);

    // R8
    pw_err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pw_err |-> $past(unlock_req && pw_mode && !lock_set));

    // R9
    simple_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pw_mode && !lock_set) |=> $stable(locked) && !pw_err);
endmodule

bind sprot_gate sprot_gate_chk #(.NUM_SECT(NUM_SECT)) u_chk (.*);

// File: tb/sprot_gate_bench.sv
module sprot_gate_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NS = 16;
    localparam int SW = $clog2(NS);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pw_mode = 1'b1;
    logic [63:0]   pw_stored = 64'hC0DE_1234_5A5A_F00D;
    logic [SW-1:0] sec_idx = '0;
    logic          prog_req = 0, erase_req = 0, dyn_set = 0, dyn_clr = 0;
    logic          nv_load = 0, pers_prog = 0, pers_erase_all = 0;
    logic          lock_set = 0, unlock_req = 0;
    logic [NS-1:0] nv_bits = '0;
    logic [63:0]   pw_cand = '0;
    logic          prog_ok, prog_deny, erase_ok, erase_deny, locked, pw_err, pers_rej;
    logic [NS-1:0] dyn_bits, pers_bits;

    int n_chk = 0;
    int n_fail = 0;
    bit chk_en = 0;
    bit finished = 0;

    // reference state
    bit [NS-1:0] m_dyn, m_pers;
    bit          m_lock, m_err, m_rej;

    always #(CLK_PERIOD/2) clk = ~clk;

    sprot_gate #(.NUM_SECT(NS)) u_sprot_gate (.*);

    task automatic check(input string req, input string what, input longint got, input longint exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, got, exp, $time);
        end
    endtask

    // behavioural model, updated at each rising edge
    always @(posedge clk) begin
        bit old_lock;
        if (!rst_n) begin
            m_dyn = '1; m_pers = '0; m_lock = pw_mode; m_err = 0; m_rej = 0;
        end else begin
            old_lock = m_lock;
            m_err = 0; m_rej = 0;
            if (nv_load) m_pers = nv_bits;
            else if ((pers_prog || pers_erase_all) && old_lock) m_rej = 1;
            else if (pers_erase_all) m_pers = '0;
            else if (pers_prog) m_pers[sec_idx] = 1'b1;
            if (dyn_set) m_dyn[sec_idx] = 1'b1;
            else if (dyn_clr) m_dyn[sec_idx] = 1'b0;
            if (lock_set) m_lock = 1;
            else if (unlock_req && pw_mode) begin
                if (pw_cand == pw_stored) m_lock = 0;
                else m_err = 1;
            end
        end
        chk_en = 1;
    end

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        bit hit;
        if (chk_en && !finished) begin
            hit = m_dyn[sec_idx] | m_pers[sec_idx];
            check("R2", "prog_ok", prog_ok, prog_req && !hit);
            check("R2", "prog_deny", prog_deny, prog_req && hit);
            check("R2", "erase_ok", erase_ok, erase_req && !hit);
            check("R2", "erase_deny", erase_deny, erase_req && hit);
            check("R3", "dyn_bits", dyn_bits, m_dyn);
            check("R5", "pers_bits", pers_bits, m_pers);
            check("R8", "locked", locked, m_lock);
            check("R8", "pw_err", pw_err, m_err);
            check("R6", "pers_rej", pers_rej, m_rej);
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
        prog_req = 0; erase_req = 0; dyn_set = 0; dyn_clr = 0; nv_load = 0;
        pers_prog = 0; pers_erase_all = 0; lock_set = 0; unlock_req = 0;
    endtask

    task automatic settle();
        step();
        @(negedge clk);
        #1;
    endtask

    task automatic rand_run(input int cycles);
        for (int i = 0; i < cycles; i++) begin
            step();
            sec_idx        = SW'($urandom);
            prog_req       = ($urandom % 2) == 0;
            erase_req      = ($urandom % 3) == 0;
            dyn_set        = ($urandom % 5) == 0;
            dyn_clr        = ($urandom % 4) == 0;
            nv_load        = ($urandom % 23) == 0;
            nv_bits        = NS'($urandom);
            pers_prog      = ($urandom % 6) == 0;
            pers_erase_all = ($urandom % 19) == 0;
            lock_set       = ($urandom % 17) == 0;
            unlock_req     = ($urandom % 7) == 0;
            pw_cand        = (($urandom % 2) == 0) ? pw_stored : pw_stored ^ (64'd1 << ($urandom % 64));
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1;
        @(negedge clk); #1;
        // R1 guarded scheme reset state
        check("R1", "reset dyn", dyn_bits, {NS{1'b1}});
        check("R1", "reset pers", pers_bits, 0);
        check("R1", "reset locked", locked, 1);

        // R4 load while frozen
        step(); nv_load = 1; nv_bits = 16'hA5C3; pers_prog = 1;
        settle();
        check("R4", "nv load", pers_bits, 16'hA5C3);
        check("R4", "no reject on load", pers_rej, 0);

        // R3 dynamic flags change while frozen
        step(); sec_idx = 2; dyn_clr = 1;
        step(); sec_idx = 4; dyn_clr = 1;
        step(); sec_idx = 4; dyn_set = 1; dyn_clr = 1;
        settle();
        check("R3", "dyn after edits", dyn_bits, 16'hFFFB);
        step(); sec_idx = 2; prog_req = 1; erase_req = 1;
        @(negedge clk); #1;
        check("R2", "sector 2 prog grant", prog_ok, 1);
        check("R2", "sector 2 erase grant", erase_ok, 1);

        // R6 edit refused while frozen
        step(); sec_idx = 2; pers_prog = 1;
        settle();
        check("R6", "pers unchanged", pers_bits, 16'hA5C3);
        check("R6", "reject pulse", pers_rej, 1);
        settle();
        check("R6", "reject one cycle", pers_rej, 0);

        // R8 near-miss key
        step(); unlock_req = 1; pw_cand = pw_stored ^ 64'h8000_0000_0000_0000;
        settle();
        check("R8", "still locked", locked, 1);
        check("R8", "mismatch pulse", pw_err, 1);

        // R7 set beats a matching key
        step(); unlock_req = 1; lock_set = 1; pw_cand = pw_stored;
        settle();
        check("R7", "lock wins", locked, 1);
        check("R7", "no compare", pw_err, 0);

        // R8 matching key releases
        step(); unlock_req = 1; pw_cand = pw_stored;
        settle();
        check("R8", "released", locked, 0);

        // R5 program then erase/program together
        step(); sec_idx = 2; pers_prog = 1;
        settle();
        check("R5", "prog one", pers_bits, 16'hA5C7);
        step(); sec_idx = 3; pers_prog = 1; pers_erase_all = 1;
        settle();
        check("R5", "erase wins", pers_bits, 0);

        // R7 freeze again, edit immediately after
        step(); lock_set = 1;
        step(); pers_erase_all = 1;
        settle();
        check("R7", "frozen again", locked, 1);
        check("R6", "reject after relock", pers_rej, 1);

        rand_run(600);

        // simple scheme
        step(); rst_n = 0; pw_mode = 0;
        step(); rst_n = 1;
        @(negedge clk); #1;
        check("R1", "simple reset locked", locked, 0);
        step(); lock_set = 1;
        step(); unlock_req = 1; pw_cand = pw_stored;
        settle();
        check("R9", "key ignored", locked, 1);
        check("R9", "no error", pw_err, 0);

        rand_run(600);

        step(); rst_n = 0; pw_mode = 1;
        step(); rst_n = 1;
        rand_run(400);

        step();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule